// File: doc/BRIEF.md
# Synchronous serial master receiver

This block receives serial words while acting as the clock master of a two-wire synchronous link. It divides the system clock by a programmable 16-bit value to produce the shift clock. The shift clock stays high while the link is idle. The block captures the serial input at each high-to-low transition of the shift clock, taking the least significant bit first. A word is 8 or 9 bits long.

Software controls reception with two requests. A one-shot request fetches a single word and then withdraws itself. A level-held continuous enable keeps words coming for as long as it stays high, and it wins over the one-shot request. Each finished word goes to a holding register together with its optional ninth bit. A ready flag marks the word as unread, and the flag drops when software strobes a read. If a word finishes while the previous one is still unread, the new word is dropped and an error flag is latched. Dropping the continuous enable clears that error. An interrupt line follows the ready flag whenever the interrupt enable is set.

Top module: `sync_master_rx`

## Requirements
- R1: After reset, `sclk_out` is 1 and `rx_ready`, `overrun`, `irq`, `sren_busy` and `rx_data` are all 0.
- R2: While a word is in progress, each half period of `sclk_out` lasts `div_val`+1 system cycles when `div_fine`=1 and 4*(`div_val`+1) cycles when `div_fine`=0. When neither request is active, `sclk_out` stays high.
- R3: `sdata_in` is captured on the system clock edge at which `sclk_out` goes low, least significant bit first. In 8-bit mode (`word9`=0), bits 0..7 of the serial word appear on `rx_data[7:0]` and `rx_bit9` reads 0.
- R4: With `word9`=1, a word has 9 bits. Serial bit 8 appears on `rx_bit9` and bits 0..7 appear on `rx_data`.
- R5: A one-cycle pulse on `sren_set` raises `sren_busy`. Exactly one word is then received, `sren_busy` drops on the edge that completes the word, and `sclk_out` then returns high and stays there.
- R6: While `cren`=1, words follow one another without a gap. After `cren` falls with `sclk_out` high, no further falling shift-clock edge occurs.
- R7: When `cren` and the one-shot request are both active, `cren` takes precedence: `sren_busy` still clears after the first word, but reception carries on with the next word.
- R8: `rx_ready` rises on the edge that completes an accepted word and clears on the edge after a one-cycle `rd_strobe`. `irq` is 1 exactly when `rx_ready`=1 and `rcie`=1.
- R9: If a word completes while `rx_ready`=1 and no read is strobed, `overrun` is set and `rx_data`/`rx_bit9` keep the earlier word.
- R10: `overrun` clears on the edge after the one at which `cren` is seen falling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| div_val | input | 16 | Shift clock divider value |
| div_fine | input | 1 | 1: half period is div_val+1 cycles; 0: four times that |
| word9 | input | 1 | 1: 9-bit words; 0: 8-bit words |
| cren | input | 1 | Continuous receive enable (level) |
| sren_set | input | 1 | One-cycle pulse requesting a single word |
| rcie | input | 1 | Receive interrupt enable |
| rd_strobe | input | 1 | One-cycle read of the holding register |
| sdata_in | input | 1 | Serial data from the slave |
| sclk_out | output | 1 | Shift clock, idle high |
| sren_busy | output | 1 | Single-word request still pending |
| rx_data | output | 8 | Received data byte |
| rx_bit9 | output | 1 | Ninth received bit |
| rx_ready | output | 1 | Unread word present |
| overrun | output | 1 | Word dropped because the previous one was unread |
| irq | output | 1 | Receive interrupt |

## Verification
`sclk_out` changes on the edge at which the divider count expires, so the final fall of a word and the rise of `rx_ready` fall on the same edge. The bench acts as the slave. It presents each bit while `sclk_out` is high and looks at the outputs on falling system-clock edges, which means a completed word is checked half a cycle after that edge. It also counts the low cycles of the first bit to check the half period. A read strobe or a falling `cren` has its effect on the next edge, so the bench checks `rx_ready` and `overrun` one full cycle after driving those inputs. The error case and the precedence case are directed; the other words use seeded random data, random divider values, random word lengths and random interrupt enables.

// File: rtl/sync_master_rx.sv
module sync_master_rx #(
  parameter int DIV_W        = 16,
  parameter int COARSE_SHIFT = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_val,
  input  logic             div_fine,
  input  logic             word9,
  input  logic             cren,
  input  logic             sren_set,
  input  logic             rcie,
  input  logic             rd_strobe,
  input  logic             sdata_in,
  output logic             sclk_out,
  output logic             sren_busy,
  output logic [7:0]       rx_data,
  output logic             rx_bit9,
  output logic             rx_ready,
  output logic             overrun,
  output logic             irq
);
  localparam int CNT_W = DIV_W + COARSE_SHIFT;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lim;
  logic [3:0]       bitcnt;
  logic [8:0]       sh;
  logic [8:0]       full;
  logic             sclk_q, cren_q;
  logic             busy, running, tick, fall, last_bit, done, accept;

  assign lim      = div_fine ? CNT_W'(div_val) : {div_val, {COARSE_SHIFT{1'b1}}};
  assign busy     = cren | sren_busy;
  assign running  = busy | ~sclk_q;
  assign tick     = running && (cnt == lim);
  assign fall     = tick && sclk_q && busy;
  assign last_bit = word9 ? (bitcnt == 4'd8) : (bitcnt == 4'd7);
  assign done     = fall && last_bit;
  assign accept   = done && (!rx_ready || rd_strobe);
  assign full     = {sdata_in, sh[8:1]};
  assign sclk_out = sclk_q;
  assign irq      = rx_ready & rcie;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      sclk_q <= 1'b1;
    end else if (!running || tick) begin
      cnt <= '0;
      if (tick) sclk_q <= ~sclk_q;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bitcnt <= '0;
      sh     <= '0;
    end else if (!busy && sclk_q) begin
      bitcnt <= '0;
    end else if (fall) begin
      sh     <= full;
      bitcnt <= last_bit ? 4'd0 : bitcnt + 4'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data  <= '0;
      rx_bit9  <= 1'b0;
      rx_ready <= 1'b0;
    end else if (accept) begin
      rx_data  <= word9 ? full[7:0] : full[8:1];
      rx_bit9  <= word9 & full[8];
      rx_ready <= 1'b1;
    end else if (rd_strobe) begin
      rx_ready <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      overrun   <= 1'b0;
      cren_q    <= 1'b0;
      sren_busy <= 1'b0;
    end else begin
      cren_q <= cren;
      if (cren_q && !cren)      overrun <= 1'b0;
      else if (done && !accept) overrun <= 1'b1;
      if (sren_set)  sren_busy <= 1'b1;
      else if (done) sren_busy <= 1'b0;
    end
  end

  p_idle_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!cren && !sren_busy && sclk_out) |=> sclk_out);

  p_single_ends_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sren_busy) |-> $past(done));

  p_read_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && !done) |=> !rx_ready);

  p_irq_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (rcie && rx_ready));

  p_overrun_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> $past(rx_ready && !rd_strobe));

  p_unread_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_ready && !rd_strobe) |=> ($stable(rx_data) && $stable(rx_bit9)));

  p_overrun_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cren) |=> !overrun);
endmodule

// File: tb/sync_master_rx_tb_top.sv
module sync_master_rx_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] div_val = 16'd0;
  logic        div_fine = 1'b1, word9 = 1'b0, cren = 1'b0, sren_set = 1'b0;
  logic        rcie = 1'b0, rd_strobe = 1'b0, sdata_in = 1'b0;
  logic        sclk_out, sren_busy, rx_bit9, rx_ready, overrun, irq;
  logic [7:0]  rx_data;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  sync_master_rx dut_i (
    .clk(clk), .rst_n(rst_n), .div_val(div_val), .div_fine(div_fine),
    .word9(word9), .cren(cren), .sren_set(sren_set), .rcie(rcie),
    .rd_strobe(rd_strobe), .sdata_in(sdata_in), .sclk_out(sclk_out),
    .sren_busy(sren_busy), .rx_data(rx_data), .rx_bit9(rx_bit9),
    .rx_ready(rx_ready), .overrun(overrun), .irq(irq)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual %0d cycles, expected fewer", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int half_cycles(input logic [15:0] d, input logic fine);
    return fine ? int'(d) + 1 : 4 * (int'(d) + 1);
  endfunction

  function automatic int exp_byte(input logic [8:0] w);
    return int'(w[7:0]);
  endfunction

  function automatic int exp_b9(input logic [8:0] w, input logic nine);
    return nine ? int'(w[8]) : 0;
  endfunction

  task automatic slave_word(input logic [8:0] w, input int nb, output int lowcnt);
    lowcnt = 0;
    for (int i = 0; i < nb; i++) begin
      sdata_in = w[i];
      do @(negedge clk); while (sclk_out !== 1'b0);
      while (sclk_out === 1'b0) begin
        if (i == 0) lowcnt++;
        @(negedge clk);
      end
    end
  endtask

  task automatic pulse_sren();
    sren_set = 1'b1;
    @(negedge clk);
    sren_set = 1'b0;
  endtask

  task automatic do_read();
    rd_strobe = 1'b1;
    @(negedge clk);
    rd_strobe = 1'b0;
  endtask

  initial begin
    int lc, nb, hi_ok;
    logic [8:0] w, w1, w2;
    void'($urandom(1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(sclk_out === 1'b1, "R1 sclk", sclk_out, 1);
    chk(rx_ready === 1'b0 && overrun === 1'b0 && irq === 1'b0, "R1 flags",
        {rx_ready, overrun, irq}, 0);
    chk(sren_busy === 1'b0 && rx_data === 8'd0, "R1 data", rx_data, 0);
    hi_ok = 1;
    repeat (20) begin
      @(negedge clk);
      if (sclk_out !== 1'b1) hi_ok = 0;
    end
    chk(hi_ok == 1, "R2 idle high", hi_ok, 1);

    // Random single-word receptions (R2..R5, R8)
    for (int k = 0; k < 30; k++) begin
      div_val  = 16'($urandom_range(0, 3));
      div_fine = ($urandom_range(0, 3) != 0);
      word9    = $urandom_range(0, 1);
      rcie     = $urandom_range(0, 1);
      w        = 9'($urandom);
      nb       = word9 ? 9 : 8;
      sdata_in = w[0];
      pulse_sren();
      chk(sren_busy === 1'b1, "R5 busy set", sren_busy, 1);
      slave_word(w, nb, lc);
      chk(lc == half_cycles(div_val, div_fine), "R2 half period", lc,
          half_cycles(div_val, div_fine));
      chk(rx_data === 8'(exp_byte(w)), word9 ? "R4 data" : "R3 data", rx_data, exp_byte(w));
      chk(rx_bit9 === 1'(exp_b9(w, word9)), word9 ? "R4 ninth" : "R3 ninth zero",
          rx_bit9, exp_b9(w, word9));
      chk(rx_ready === 1'b1 && irq === rcie, "R8 ready/irq", {rx_ready, irq}, {1'b1, rcie});
      chk(sren_busy === 1'b0, "R5 busy cleared", sren_busy, 0);
      hi_ok = 1;
      repeat (3 * half_cycles(div_val, div_fine)) begin
        @(negedge clk);
        if (sclk_out !== 1'b1) hi_ok = 0;
      end
      chk(hi_ok == 1, "R5 one word only", hi_ok, 1);
      do_read();
      chk(rx_ready === 1'b0 && irq === 1'b0, "R8 read clears", rx_ready, 0);
    end

    // Precedence: both requests active (R7)
    div_val = 16'd4; div_fine = 1'b1; word9 = 1'b0; rcie = 1'b1;
    w1 = 9'h0A5; w2 = 9'h03C;
    sdata_in = w1[0];
    cren = 1'b1;
    pulse_sren();
    slave_word(w1, 8, lc);
    chk(sren_busy === 1'b0, "R7 single cleared", sren_busy, 0);
    chk(rx_data === 8'hA5, "R7 first word", rx_data, 8'hA5);
    do_read();
    slave_word(w2, 8, lc);
    chk(rx_data === 8'h3C && rx_ready === 1'b1, "R7 continued", rx_data, 8'h3C);
    do_read();

    // Continuous with overrun (R6, R9, R10)
    word9 = 1'b1;
    w1 = 9'h1C3; w2 = 9'h05A;
    slave_word(w1, 9, lc);
    chk(rx_data === 8'hC3 && rx_bit9 === 1'b1, "R6 continuous word", rx_data, 8'hC3);
    slave_word(w2, 9, lc);
    chk(overrun === 1'b1, "R9 overrun set", overrun, 1);
    chk(rx_data === 8'hC3 && rx_bit9 === 1'b1, "R9 old word kept", rx_data, 8'hC3);
    cren = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk(overrun === 1'b0, "R10 overrun cleared", overrun, 0);
    chk(rx_ready === 1'b1, "R9 ready kept", rx_ready, 1);
    hi_ok = 1;
    repeat (40) begin
      @(negedge clk);
      if (sclk_out !== 1'b1) hi_ok = 0;
    end
    chk(hi_ok == 1, "R6 stops after cren", hi_ok, 1);
    do_read();

    // Single-word overrun, coarse divider (R9, R2)
    div_val = 16'd1; div_fine = 1'b0; word9 = 1'b0;
    w1 = 9'h081; w2 = 9'h07E;
    sdata_in = w1[0];
    pulse_sren();
    slave_word(w1, 8, lc);
    chk(lc == 8, "R2 coarse half period", lc, 8);
    sdata_in = w2[0];
    pulse_sren();
    slave_word(w2, 8, lc);
    chk(overrun === 1'b1 && rx_data === 8'h81, "R9 single overrun", rx_data, 8'h81);
    do_read();
    chk(rx_ready === 1'b0 && overrun === 1'b1, "R10 overrun needs cren fall", overrun, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule